// File: doc/BRIEF.md
# Opcode-Driven Serial Register Port

This block is a serial slave that gives a host access to a small byte-wide register file over a four-wire synchronous link. The link has a clock, an active-low select, a data input and a data output. Every select frame opens with a one-byte command. The command picks one of four operations: a burst write with an address that increments on its own, a pipelined random read, a sequential dump that spans two frames, or a return of every register to its power-up value. Data travels most significant bit first.

The serial clock, select and data input are sampled on the fast system clock through two-flop synchronizers, and their edges are found in that domain. Each received bit is taken when the serial clock rises. The output bit moves on after the serial clock falls. Outside a frame the data output is held low, so it can share a pin with other sources. Twelve writable registers sit at addresses 0x00 to 0x0B and are presented in parallel to the rest of the chip. Address 0x0C reads a status byte supplied from outside. Bit 0 of register 0x00 lets a sleep input lock the port.

Top module: `spi_cmd_regs`

## Requirements
- R1: Bits move MSB first. The input bit is taken on a rising serial clock, and the output bit changes only after a falling serial clock. `sdo_o` is 0 whenever select is high.
- R2: After `rst_n`, register 0x01 holds 0x10 and every other writable register holds 0x00. `regs_o[8*k+7:8*k]` carries register k.
- R3: Command 0x01 takes a start address byte, then any number of data bytes. Data byte j goes to the start address plus j, and the address wraps modulo 256.
- R4: Command 0x02 takes a stream of address bytes. The value at each address is shifted out during the byte that follows that address. The output during the command byte and the first address byte carries no meaning. Address 0x0C returns `status_i`, and addresses above 0x0C return 0x00.
- R5: Writes that land on address 0x0C or above are discarded and change no register.
- R6: Command 0x03 followed by a start address arms a dump. In the next frame, byte j on the output is the value at the start address plus j, whatever the host sends. The frame after that is decoded as a normal command frame again.
- R7: Command 0x04 returns every writable register to its R2 value. Any later bytes in the same frame are ignored.
- R8: Any other command value makes the rest of its frame ignored: no write, and the output stays 0. The next frame is again decoded from its first byte as a command.
- R9: If `sleep_i` is 1 and bit 0 of register 0x00 is 1 when a frame opens, the whole frame is ignored: no register changes, the output stays 0, and an armed dump is dropped.
- R10: A byte left incomplete when select rises is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| cs_n_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data from the host |
| sleep_i | input | 1 | Device sleep indication, used with the lock bit |
| status_i | input | 8 | Read-only status byte seen at address 0x0C |
| sdo_o | output | 1 | Serial data to the host, low outside frames |
| regs_o | output | 96 | Writable registers, register k at bits 8k+7..8k |

## Verification
The assertions assume that the host keeps each serial clock phase, and the gap between the last clock edge and a select rise, longer than about four system clocks. They also assume that `sleep_i` changes only while select is high. Under those conditions the registers must be quiet after select has been high for a few cycles, and a locked frame can never write. The stimulus holds every serial clock phase for eight system clocks and changes `sleep_i` only between frames. Under those conditions each output bit settles well before the host samples it, just ahead of the next rising edge.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [2:0] {
    ST_OPC, ST_WADDR, ST_WDATA, ST_RADDR,
    ST_RAADDR, ST_RASTRM, ST_SKIP, ST_LOCKED
  } ctl_st_e;

  localparam logic [7:0] OPC_WRITE = 8'h01;
  localparam logic [7:0] OPC_READ  = 8'h02;
  localparam logic [7:0] OPC_RDALL = 8'h03;
  localparam logic [7:0] OPC_RESET = 8'h04;

  // power-up value of writable register idx
  function automatic logic [7:0] reg_init(input int idx);
    return (idx == 1) ? 8'h10 : 8'h00;
  endfunction
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          cs_n_i,
  input  logic          sdi_i,
  input  logic [DW-1:0] nxt_byte_i,
  output logic [DW-1:0] rx_byte_o,
  output logic          byte_done_o,
  output logic          frame_start_o,
  output logic          cs_act_o,
  output logic          sdo_o
);
  localparam int CNT_W = $clog2(DW);

  logic [2:0] pins_s;
  logic       sclk_s, cs_n_s, sdi_s;
  logic       sclk_d, cs_act_d;
  logic       cs_act, rise, fall;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DW-1:0]    rx_q, rx_n, tx_q, tx_n;
  logic             done_q, done_n;

  spi_cmd_sync #(.WIDTH(3), .STAGES(STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sclk_i, cs_n_i, sdi_i}),
    .q_o(pins_s)
  );
  assign {sclk_s, cs_n_s, sdi_s} = pins_s;

  assign cs_act = !cs_n_s;
  assign rise   = cs_act && sclk_s && !sclk_d;
  assign fall   = cs_act && !sclk_s && sclk_d;
  assign frame_start_o = cs_act && !cs_act_d;

  always_comb begin
    cnt_n  = cnt_q;
    rx_n   = rx_q;
    tx_n   = tx_q;
    done_n = 1'b0;
    if (!cs_act) begin
      cnt_n = '0;
      tx_n  = '0;
    end else if (frame_start_o) begin
      cnt_n = '0;
      tx_n  = nxt_byte_i;
    end else if (rise) begin
      rx_n = {rx_q[DW-2:0], sdi_s};
      if (cnt_q == CNT_W'(DW-1)) begin
        cnt_n  = '0;
        done_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else if (fall) begin
      if (cnt_q == '0) tx_n = nxt_byte_i;
      else             tx_n = {tx_q[DW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      cs_act_d <= 1'b0;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      cs_act_d <= cs_act;
      cnt_q    <= cnt_n;
      rx_q     <= rx_n;
      tx_q     <= tx_n;
      done_q   <= done_n && cs_act;
    end
  end

  assign rx_byte_o   = rx_q;
  assign byte_done_o = done_q && cs_act;
  assign cs_act_o    = cs_act;
  assign sdo_o       = cs_act && tx_q[DW-1];
endmodule

// File: rtl/spi_cmd_rf.sv
module spi_cmd_rf
  import spi_cmd_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 8,
  parameter int N_WR      = 12,
  parameter int STAT_ADDR = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             clr_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [DW-1:0]    status_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [N_WR*DW-1:0] regs_o
);
  logic [DW-1:0] r_q [N_WR];

  for (genvar i = 0; i < N_WR; i++) begin : g_reg
    logic          hit;
    logic [DW-1:0] r_n;
    assign hit = wr_en_i && (wr_addr_i == AW'(i));
    always_comb begin
      r_n = r_q[i];
      if (clr_i)    r_n = DW'(reg_init(i));
      else if (hit) r_n = wr_data_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q[i] <= DW'(reg_init(i));
      else        r_q[i] <= r_n;
    end
    assign regs_o[i*DW +: DW] = r_q[i];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AW'(STAT_ADDR)) rd_data_o = status_i;
    for (int i = 0; i < N_WR; i++) begin
      if (rd_addr_i == AW'(i)) rd_data_o = r_q[i];
    end
  end
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act_i,
  input  logic          frame_start_i,
  input  logic          byte_done_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          lock_now_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          clr_o,
  output logic [DW-1:0] nxt_byte_o,
  output logic          blocked_o
);
  ctl_st_e       st_q, st_n;
  logic [AW-1:0] ptr_q, ptr_n, ras_q, ras_n;
  logic          rap_q, rap_n;
  logic [DW-1:0] nxt_q, nxt_n;

  always_comb begin
    if (!cs_act_i)            rd_addr_o = ras_q;
    else if (st_q == ST_RADDR) rd_addr_o = AW'(rx_byte_i);
    else                      rd_addr_o = ptr_q;
  end

  assign wr_en_o   = byte_done_i && (st_q == ST_WDATA);
  assign wr_addr_o = ptr_q;
  assign wr_data_o = rx_byte_i;
  assign clr_o     = byte_done_i && (st_q == ST_OPC) && (rx_byte_i == OPC_RESET);
  assign blocked_o = (st_q == ST_LOCKED);
  assign nxt_byte_o = nxt_q;

  always_comb begin
    st_n  = st_q;
    ptr_n = ptr_q;
    ras_n = ras_q;
    rap_n = rap_q;
    nxt_n = nxt_q;
    if (!cs_act_i) begin
      st_n  = ST_OPC;
      nxt_n = (rap_q && !lock_now_i) ? rd_data_i : '0;
    end else if (frame_start_i) begin
      rap_n = 1'b0;
      if (rap_q) ptr_n = ras_q + 1'b1;
      if (lock_now_i)  st_n = ST_LOCKED;
      else if (rap_q)  st_n = ST_RASTRM;
      else             st_n = ST_OPC;
    end else if (byte_done_i) begin
      nxt_n = '0;
      case (st_q)
        ST_OPC: begin
          case (rx_byte_i)
            OPC_WRITE: st_n = ST_WADDR;
            OPC_READ:  st_n = ST_RADDR;
            OPC_RDALL: st_n = ST_RAADDR;
            default:   st_n = ST_SKIP;
          endcase
        end
        ST_WADDR: begin
          ptr_n = AW'(rx_byte_i);
          st_n  = ST_WDATA;
        end
        ST_WDATA:  ptr_n = ptr_q + 1'b1;
        ST_RADDR:  nxt_n = rd_data_i;
        ST_RAADDR: begin
          ras_n = AW'(rx_byte_i);
          rap_n = 1'b1;
          st_n  = ST_SKIP;
        end
        ST_RASTRM: begin
          nxt_n = rd_data_i;
          ptr_n = ptr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OPC;
      ptr_q <= '0;
      ras_q <= '0;
      rap_q <= 1'b0;
      nxt_q <= '0;
    end else begin
      st_q  <= st_n;
      ptr_q <= ptr_n;
      ras_q <= ras_n;
      rap_q <= rap_n;
      nxt_q <= nxt_n;
    end
  end
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs #(
  parameter int DW          = 8,
  parameter int AW          = 8,
  parameter int N_WR        = 12,
  parameter int STAT_ADDR   = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               cs_n_i,
  input  logic               sdi_i,
  input  logic               sleep_i,
  input  logic [DW-1:0]      status_i,
  output logic               sdo_o,
  output logic [N_WR*DW-1:0] regs_o
);
  logic [DW-1:0] rx_byte, nxt_byte, rd_data, wr_data;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          byte_done, frame_start, cs_act;
  logic          wr_en, rf_clr, ctl_blocked, sleep_s, lock_now;

  spi_cmd_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sleep_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sleep_i), .q_o(sleep_s)
  );

  assign lock_now = sleep_s && regs_o[0];

  spi_cmd_shift #(.DW(DW), .STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_i(sclk_i), .cs_n_i(cs_n_i), .sdi_i(sdi_i),
    .nxt_byte_i(nxt_byte),
    .rx_byte_o(rx_byte), .byte_done_o(byte_done),
    .frame_start_o(frame_start), .cs_act_o(cs_act),
    .sdo_o(sdo_o)
  );

  spi_cmd_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cs_act_i(cs_act), .frame_start_i(frame_start),
    .byte_done_i(byte_done), .rx_byte_i(rx_byte),
    .lock_now_i(lock_now), .rd_data_i(rd_data),
    .rd_addr_o(rd_addr), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .clr_o(rf_clr), .nxt_byte_o(nxt_byte),
    .blocked_o(ctl_blocked)
  );

  spi_cmd_rf #(.DW(DW), .AW(AW), .N_WR(N_WR), .STAT_ADDR(STAT_ADDR)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .clr_i(rf_clr), .rd_addr_i(rd_addr), .status_i(status_i),
    .rd_data_o(rd_data), .regs_o(regs_o)
  );
endmodule

// File: rtl/spi_cmd_regs_chk.sv
module spi_cmd_regs_chk
  import spi_cmd_pkg::*;
#(
  parameter int DW   = 8,
  parameter int N_WR = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n_i,
  input logic               sdo_o,
  input logic [N_WR*DW-1:0] regs_o,
  input logic               clr,
  input logic               blocked
);
  logic [N_WR*DW-1:0] init_img;
  always_comb begin
    for (int i = 0; i < N_WR; i++) init_img[i*DW +: DW] = DW'(reg_init(i));
  end

  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !sdo_o); // R1

  AST_REGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3) &&
     $past(cs_n_i, 4) && $past(cs_n_i, 5)) |-> $stable(regs_o)); // R3

  AST_CLR_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (regs_o == init_img)); // R7

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !clr); // R7

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> $stable(regs_o)); // R9
endmodule

bind spi_cmd_regs spi_cmd_regs_chk #(.DW(DW), .N_WR(N_WR)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sdo_o(sdo_o),
  .regs_o(regs_o), .clr(rf_clr), .blocked(ctl_blocked)
);

// File: tb/spi_cmd_regs_tb_top.sv
module spi_cmd_regs_tb_top;
  localparam int HALF = 8;
  localparam int NW   = 12;

  logic clk, rst_n, sclk, cs_n, sdi, sleep;
  logic [7:0] status;
  logic sdo;
  logic [NW*8-1:0] regs;

  spi_cmd_regs dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
    .sleep_i(sleep), .status_i(status), .sdo_o(sdo), .regs_o(regs)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [7:0] mreg [NW];
  bit         m_pend;
  logic [7:0] m_start;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  task automatic check(input string tag, input logic [NW*8-1:0] act, input logic [NW*8-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NW*8-1:0] m_image();
    logic [NW*8-1:0] v;
    for (int i = 0; i < NW; i++) v[i*8 +: 8] = mreg[i];
    return v;
  endfunction

  function automatic logic [7:0] m_rd(input logic [7:0] a);
    if (a < 8'(NW)) return mreg[a];
    if (a == 8'h0C) return status;
    return 8'h00;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NW; i++) mreg[i] = (i == 1) ? 8'h10 : 8'h00;
  endtask

  // drive one frame from txq, extra bits of an unfinished byte, collect rxq
  task automatic run_frame(input int tail_bits);
    rxq.delete();
    @(negedge clk);
    cs_n = 1'b0;
    foreach (txq[k]) begin
      logic [7:0] got;
      for (int b = 7; b >= 0; b--) begin
        sdi = txq[k][b];
        repeat (HALF) @(negedge clk);
        got[b] = sdo;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
      end
      rxq.push_back(got);
    end
    for (int b = 0; b < tail_bits; b++) begin
      sdi = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    sdi  = 1'b0;
  endtask

  // behavioural reference of one frame: compare output bytes, then apply effects
  task automatic model_frame(input string tag);
    logic [7:0] exp[$];
    logic [7:0] ptr;
    bit lock;
    int care_from;
    lock = sleep && mreg[0][0];
    care_from = 0;
    for (int k = 0; k < txq.size(); k++) exp.push_back(8'h00);
    if (m_pend) begin
      m_pend = 0;
      if (!lock) for (int k = 0; k < txq.size(); k++) exp[k] = m_rd(m_start + 8'(k));
    end else if (!lock && txq.size() > 0) begin
      case (txq[0])
        8'h01: if (txq.size() >= 2) begin
          ptr = txq[1];
          for (int k = 2; k < txq.size(); k++) begin
            if (ptr < 8'(NW)) mreg[ptr] = txq[k];
            ptr = ptr + 8'd1;
          end
        end
        8'h02: begin
          care_from = 2;
          for (int k = 2; k < txq.size(); k++) exp[k] = m_rd(txq[k-1]);
        end
        8'h03: if (txq.size() >= 2) begin
          m_pend = 1;
          m_start = txq[1];
        end
        8'h04: m_reset();
        default: ;
      endcase
    end
    for (int k = care_from; k < rxq.size(); k++)
      check($sformatf("%s byte%0d", tag, k), {{(NW*8-8){1'b0}}, rxq[k]},
            {{(NW*8-8){1'b0}}, exp[k]});
  endtask

  task automatic frame(input string tag, input int tail_bits);
    run_frame(tail_bits);
    model_frame(tag);
    repeat (3 * HALF) @(negedge clk);
    check({tag, " regs"}, regs, m_image());
  endtask

  // every clock: once select has been high a while, registers match the model
  int idle = 0;
  always @(negedge clk) begin
    if (!rst_n || !cs_n) idle = 0;
    else idle++;
    if (rst_n && idle > 6 && !finished) begin
      check("R3 per-clock regs", regs, m_image());
      check("R1 idle sdo", {{(NW*8-1){1'b0}}, sdo}, '0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0; sleep = 1'b0;
    status = 8'hC5;
    m_reset(); m_pend = 0; m_start = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 reset image", regs, m_image());
    check("R1 reset sdo", {{(NW*8-1){1'b0}}, sdo}, '0);

    txq = '{8'h01, 8'h02, 8'h81, 8'h3C, 8'hA5, 8'h7E};
    frame("R3 burst write", 0);
    txq = '{8'h02, 8'h03, 8'h01, 8'h0C, 8'h20, 8'h04, 8'h02, 8'h00};
    frame("R4 random read", 0);
    txq = '{8'h02, 8'h05, 8'h02, 8'h00};
    frame("R1 msb first read", 0);
    txq = '{8'h01, 8'h0A, 8'h11, 8'h22, 8'h33, 8'h44};
    frame("R5 write past end", 0);
    txq = '{8'h02, 8'h0B, 8'h0C, 8'h0D, 8'h00};
    frame("R5 readback", 0);
    txq = '{8'h01, 8'hFF, 8'h99, 8'h5A};
    frame("R3 address wrap", 0);
    txq = '{8'h03, 8'h09};
    frame("R6 dump arm", 0);
    txq = '{8'hFF, 8'h00, 8'h12, 8'h34, 8'h56, 8'h78};
    frame("R6 dump stream", 0);
    txq = '{8'h02, 8'h01, 8'h00};
    frame("R6 after dump", 0);
    txq = '{8'h04, 8'h01, 8'h02, 8'h55};
    frame("R7 reset cmd", 0);
    txq = '{8'h07, 8'h01, 8'h02, 8'h33};
    frame("R8 unknown cmd", 0);
    txq = '{8'h01, 8'h03, 8'h6D};
    frame("R8 next frame", 0);
    txq = '{8'h01, 8'h05};
    frame("R10 partial byte", 4);
    txq = '{8'h01, 8'h00, 8'h01};
    frame("R9 set lock", 0);
    sleep = 1'b1;
    repeat (4) @(negedge clk);
    txq = '{8'h01, 8'h02, 8'hEE};
    frame("R9 locked write", 0);
    txq = '{8'h02, 8'h03, 8'h00, 8'h00};
    frame("R9 locked read", 0);
    sleep = 1'b0;
    repeat (4) @(negedge clk);
    txq = '{8'h03, 8'h03};
    frame("R6 arm before lock", 0);
    sleep = 1'b1;
    repeat (4) @(negedge clk);
    txq = '{8'h00, 8'h00};
    frame("R9 dump dropped", 0);
    sleep = 1'b0;
    repeat (4) @(negedge clk);
    txq = '{8'h02, 8'h03, 8'h00, 8'h00};
    frame("R9 unlocked read", 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule